// File: doc/BRIEF.md
# Dual link-speed LED conditioner

This block drives two indicator LEDs, one for 100 Mb/s activity and one for 1000 Mb/s activity. Each LED has a 4-bit selector that chooses one of sixteen internal status inputs. The chosen input is synchronised and can then pass through a pulse stretcher, a blink gate, or both. If both of those stages are disabled, the input bypasses the registers and reaches the pin through combinational logic only.

A single 16-bit configuration word holds the settings for both LEDs. It is written and read through a simple synchronous port. The hardware reset and a software reset input both load the same default word. A free-running prescaler is shared by both LEDs and sets the blink rate. When stretching is enabled for an LED, the stretcher output feeds that LED's blink gate. A short activity pulse therefore first widens into a visible window, and the LED then blinks inside that window.

Top module: `led_conditioner`

## Requirements
- R1: After reset the configuration word reads 0x0923. Its layout is: [3:0] first-LED source select, [4] first-LED blink disable, [5] first-LED stretch disable, [9:6] second-LED source select, [10] second-LED blink disable, [11] second-LED stretch disable. A disable bit equal to 1 turns its stage off.
- R2: A write takes effect on the next clock edge. Bits 15:12 always read 0, and writes to them are ignored.
- R3: An asserted software reset reloads 0x0923 on the next edge. It wins over a write in the same cycle.
- R4: Each LED follows `status_i[sel]`, where sel is the LED's 4-bit source select field.
- R5: When an LED has both its blink disable and its stretch disable set, the LED equals `status_i[sel]` in the same cycle, with no clock edge in between.
- R6: In any other setting the selected input passes through two flip-flops. A change in the input reaches the LED after two clock edges.
- R7: With stretch enabled, the LED stays on for STRETCH_CYC cycles after the synchronised input falls. Each new assertion restarts this hold. A one-cycle pulse with blink disabled therefore lights the LED for STRETCH_CYC+1 cycles.
- R8: With blink enabled, an active LED is on only while bit BLINK_LOG2-1 of a free-running counter is 1. The counter clears at reset, so the blink period is 2^BLINK_LOG2 cycles at a 50% duty cycle.
- R9: With both stages enabled, the stretched signal is the one that gets gated by the blink phase.
- R10: Outside the bypass case, an LED whose stretched and synchronised input is inactive is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sw_rst_i | input | 1 | Synchronous software reset of the configuration word |
| reg_we_i | input | 1 | Configuration write enable |
| reg_wdata_i | input | 16 | Configuration write data |
| reg_rdata_o | output | 16 | Configuration read data |
| status_i | input | 16 | Internal status inputs available for selection |
| led_fast_o | output | 1 | 100 Mb/s indicator LED |
| led_gig_o | output | 1 | 1000 Mb/s indicator LED |

## Verification
Two pairs of events can land in the same cycle. The first pair is a register write arriving together with a software reset. The bench drives both in one cycle and expects the reset word to win. The second pair is a new input assertion arriving while the stretch counter is already counting down, or just as it reaches zero. Sparse random status traffic combined with random configuration rewrites provokes this case many times. Each cycle is then judged against a bench model of the synchroniser, the hold counter and the prescaler phase, built from the requirements.

// File: rtl/led_cond_pkg.sv
package led_cond_pkg;
  localparam int NUM_SRC = 16;
  localparam int SEL_W   = $clog2(NUM_SRC);
  localparam int NUM_LED = 2;
  localparam logic [15:0] CFG_DEFAULT = 16'h0923;
  localparam logic [15:0] CFG_MASK    = 16'h0FFF;

  typedef struct packed {
    logic             stretch_dis;
    logic             blink_dis;
    logic [SEL_W-1:0] sel;
  } led_cfg_t;

  localparam int CFG_W = $bits(led_cfg_t);
endpackage

// File: rtl/led_cfg_reg.sv
module led_cfg_reg
  import led_cond_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sw_rst_i,
  input  logic        we_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  output led_cfg_t    cfg_o [NUM_LED]
);
  logic [15:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= CFG_DEFAULT;
    else if (sw_rst_i) cfg_q <= CFG_DEFAULT;
    else if (we_i)     cfg_q <= wdata_i & CFG_MASK;
  end

  assign rdata_o = cfg_q;

  for (genvar g = 0; g < NUM_LED; g++) begin : g_cfg
    assign cfg_o[g] = led_cfg_t'(cfg_q[g*CFG_W +: CFG_W]);
  end

  a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && !sw_rst_i |=> rdata_o == ($past(wdata_i) & CFG_MASK));
  a_r3_swrst_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_i |=> rdata_o == CFG_DEFAULT);
endmodule

// File: rtl/led_prescaler.sv
module led_prescaler #(
  parameter int BLINK_LOG2 = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic phase_o
);
  logic [BLINK_LOG2-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign phase_o = cnt_q[BLINK_LOG2-1];

  a_r8_phase_flips: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cnt_q) |=> (phase_o != $past(phase_o)));
endmodule

// File: rtl/led_channel.sv
module led_channel
  import led_cond_pkg::*;
#(
  parameter int STRETCH_CYC = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  led_cfg_t           cfg_i,
  input  logic [NUM_SRC-1:0] status_i,
  input  logic               phase_i,
  output logic               led_o
);
  localparam int CW = $clog2(STRETCH_CYC + 1);

  logic          raw, bypass, sync1_q, sync2_q, act;
  logic [CW-1:0] hold_q;

  assign raw    = status_i[cfg_i.sel];
  assign bypass = cfg_i.blink_dis & cfg_i.stretch_dis;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= raw;
      sync2_q <= sync1_q;
    end
  end

  // hold counter runs regardless of mode so enabling stretch is seamless
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             hold_q <= '0;
    else if (sync2_q)        hold_q <= CW'(STRETCH_CYC);
    else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
  end

  assign act   = cfg_i.stretch_dis ? sync2_q : (sync2_q | (hold_q != '0));
  assign led_o = bypass ? raw : (cfg_i.blink_dis ? act : (act & phase_i));

  a_r7_stretch_covers_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i.stretch_dis && $fell(sync2_q) |-> act);
  a_r8_blink_dark_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bypass && !cfg_i.blink_dis && !phase_i |-> !led_o);
  a_r10_idle_dark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bypass && !act |-> !led_o);
endmodule

// File: rtl/led_conditioner.sv
module led_conditioner
  import led_cond_pkg::*;
#(
  parameter int BLINK_LOG2  = 4,
  parameter int STRETCH_CYC = 6
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sw_rst_i,
  input  logic        reg_we_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] reg_rdata_o,
  input  logic [15:0] status_i,
  output logic        led_fast_o,
  output logic        led_gig_o
);
  led_cfg_t           cfg [NUM_LED];
  logic               phase;
  logic [NUM_LED-1:0] led;

  led_cfg_reg u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sw_rst_i(sw_rst_i),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .cfg_o   (cfg)
  );

  led_prescaler #(.BLINK_LOG2(BLINK_LOG2)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phase_o(phase)
  );

  for (genvar g = 0; g < NUM_LED; g++) begin : g_led
    led_channel #(.STRETCH_CYC(STRETCH_CYC)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cfg_i   (cfg[g]),
      .status_i(status_i),
      .phase_i (phase),
      .led_o   (led[g])
    );
  end

  assign led_fast_o = led[0];
  assign led_gig_o  = led[1];
endmodule

// File: tb/tb_led_conditioner.sv
module tb_led_conditioner;
  localparam int CLK_PERIOD  = 10;
  localparam int BLINK_LOG2  = 4;
  localparam int STRETCH_CYC = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_rst = 1'b0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [15:0] status = '0;
  logic        led_fast, led_gig;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  led_conditioner #(.BLINK_LOG2(BLINK_LOG2), .STRETCH_CYC(STRETCH_CYC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sw_rst_i(sw_rst), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .status_i(status),
    .led_fast_o(led_fast), .led_gig_o(led_gig)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // requirement model
  logic [15:0] m_reg;
  logic [1:0]  m_s1, m_s2;
  int          m_hold [2];
  logic [BLINK_LOG2-1:0] m_pre;

  function automatic logic m_raw(int i);
    logic [3:0] s = m_reg[i*6 +: 4];
    return status[s];
  endfunction

  function automatic logic exp_led(int i);
    logic bd = m_reg[i*6+4];
    logic sd = m_reg[i*6+5];
    logic a;
    if (bd && sd) return m_raw(i);
    a = sd ? m_s2[i] : (m_s2[i] || m_hold[i] != 0);
    return bd ? a : (a & m_pre[BLINK_LOG2-1]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg <= 16'h0923; m_s1 <= '0; m_s2 <= '0;
      m_hold[0] <= 0; m_hold[1] <= 0; m_pre <= '0;
    end else begin
      m_pre <= m_pre + 1'b1;
      for (int i = 0; i < 2; i++) begin
        m_s1[i] <= m_raw(i);
        m_s2[i] <= m_s1[i];
        if (m_s2[i]) m_hold[i] <= STRETCH_CYC;
        else if (m_hold[i] != 0) m_hold[i] <= m_hold[i] - 1;
      end
      if (sw_rst) m_reg <= 16'h0923;
      else if (we) m_reg <= wdata & 16'h0FFF;
    end
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_model(string req);
    chk({req, " fast"}, 16'(led_fast), 16'(exp_led(0)));
    chk({req, " gig"},  16'(led_gig),  16'(exp_led(1)));
    chk({req, " rdata"}, rdata, m_reg);
  endtask

  task automatic cycle();
    @(negedge clk);
    we = 1'b0; sw_rst = 1'b0;
  endtask

  task automatic write_cfg(logic [15:0] d);
    @(negedge clk); we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int hi;
    void'($urandom(32'd1234));
    #(CLK_PERIOD*3);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1 reset word", rdata, 16'h0923);
    chk_model("R1 reset leds");

    // R2 reserved bits
    write_cfg(16'hFFFF); #1;
    chk("R2 reserved ignored", rdata, 16'h0FFF);

    // R3 software reset beats simultaneous write
    @(negedge clk); we = 1'b1; wdata = 16'h0555; sw_rst = 1'b1;
    @(negedge clk); we = 1'b0; sw_rst = 1'b0; #1;
    chk("R3 swrst wins", rdata, 16'h0923);

    // R5 bypass: first LED sel 7, second sel 9, both disables set
    write_cfg({4'h0, 2'b11, 4'd9, 2'b11, 4'd7});
    status = 16'h0080; #1;
    chk("R5 bypass fast on", 16'(led_fast), 16'd1);
    chk("R5 bypass gig off", 16'(led_gig), 16'd0);
    status = 16'h0200; #1;
    chk("R5 bypass fast off", 16'(led_fast), 16'd0);
    chk("R4 gig follows sel 9", 16'(led_gig), 16'd1);
    status = '0;

    // R6 two-edge latency, stretch on blink off -> use stretch off, blink off impossible; use blink dis + stretch en with short check
    write_cfg({4'h0, 2'b01, 4'd2, 2'b01, 4'd2});
    repeat (STRETCH_CYC + 4) cycle();
    status = 16'h0004; #1;
    chk("R6 no change before edges", 16'(led_fast), 16'd0);
    cycle(); #1;
    chk("R6 one edge", 16'(led_fast), 16'd0);
    cycle(); #1;
    chk("R6 two edges", 16'(led_fast), 16'd1);
    status = '0;
    repeat (STRETCH_CYC + 4) cycle();

    // R7 one-cycle pulse lit for STRETCH_CYC+1 cycles
    @(negedge clk); status = 16'h0004;
    @(negedge clk); status = '0;
    hi = 0;
    for (int k = 0; k < 20; k++) begin
      #1; if (led_fast) hi++;
      @(negedge clk);
    end
    chk("R7 stretch span", 16'(hi), 16'(STRETCH_CYC + 1));

    // R8 blink 50% duty with held input, stretch off
    write_cfg({4'h0, 2'b10, 4'd2, 2'b10, 4'd2});
    status = 16'h0004;
    repeat (4) cycle();
    hi = 0;
    for (int k = 0; k < 2**(BLINK_LOG2+1); k++) begin
      #1; if (led_gig) hi++;
      @(negedge clk);
    end
    chk("R8 blink duty", 16'(hi), 16'(2**BLINK_LOG2));
    #1; chk_model("R8 blink phase");

    // R9 both stages on, R10 idle, random traffic against model
    write_cfg({4'h0, 2'b00, 4'd5, 2'b00, 4'd3});
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      we = ($urandom_range(0, 39) == 0);
      wdata = 16'($urandom);
      sw_rst = ($urandom_range(0, 299) == 0);
      if (($urandom_range(0, 2)) == 0) status = 16'($urandom) & 16'($urandom) & 16'($urandom);
      #1;
      chk_model("R4 R6 R7 R9 R10 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule